// File: doc/BRIEF.md
# Predicated Contiguous Vector Load/Store Unit

This block prepares one contiguous vector memory access under a per-lane predicate. A 4-bit data-type code sets two widths: the width of each element in memory and the width of each lane in the vector register. It also sets whether a narrow memory element is sign-extended or zero-extended into its lane. From a base address and an offset, the block computes the effective address and the number of bytes the access covers. The offset is either a signed immediate scaled by the whole access or a register value scaled by the memory element size.

For stores, the block packs each active lane's data, truncated to the memory element width, into a little-endian byte image. It also produces a byte write-enable mask in which inactive lanes are switched off. For loads, it takes the memory byte image and widens each element into its register lane, and it writes zero into inactive lanes. A replicate mode reads one element and copies it into every active lane.

The block also detects three faults: an unaligned stack-pointer base, a signed data-type code used with a store, and an illegal mix of request flags. A faulting request makes no access. All results are registered and appear one cycle after a valid request.

Top module: `vls_contig_unit`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise. All result outputs load only on a valid request and otherwise hold their values. Reset clears every output to zero.
- R2: The code gives (register lane bytes, memory element bytes, extension), with S meaning sign extension and U meaning zero extension: 0→(1,1,U), 1→(2,1,U), 2→(4,1,U), 3→(8,1,U), 4→(8,4,S), 5→(2,2,U), 6→(4,2,U), 7→(8,2,U), 8→(8,2,S), 9→(4,2,S), A→(4,4,U), B→(8,4,U), C→(8,1,S), D→(4,1,S), E→(2,1,S), F→(8,8,U). The lane count n is 16 divided by the register lane bytes.
- R3: A store that uses code 4, 8, 9, C, D or E sets `rsp_undef` and enables no byte. Every other store code, and every load code, leaves `rsp_undef` clear.
- R4: With `req_imm_mode`=1 and no replicate, the effective address is base + sext(imm) × n × memory element bytes, taken modulo 2^64.
- R5: With `req_imm_mode`=0 and no replicate, the effective address is base + offset × memory element bytes, taken modulo 2^64.
- R6: `rsp_bytes` is n × memory element bytes. In replicate mode it is one memory element.
- R7: On a load, lane i occupies register bytes starting at i × lane bytes. Its predicate is `req_pred[i × lane bytes]`. An active lane receives the memory element at byte offset i × element bytes, extended as R2 gives. An inactive lane reads zero. A load drives `rsp_wen` and `rsp_wdata` to zero.
- R8: On a store, lane i's low element-width bytes are placed at memory byte i × element bytes. Those bytes are enabled in `rsp_wen` when the lane is active. Inactive lanes, and bytes beyond `rsp_bytes`, get data zero and enable zero. A store drives `rsp_ld_data` to zero.
- R9: In replicate mode the address is base + sext(imm) × element bytes, whatever `req_imm_mode` is. Every active lane receives the element at memory byte 0, extended. Inactive lanes read zero.
- R10: `rsp_align_fault` is set when `req_base_sp` and `req_align_en` are both high and base bits [3:0] are nonzero.
- R11: `rsp_illegal` is set when `req_repl` is high together with `req_ff` or with `req_store`.
- R12: When any of the three faults is set, `rsp_bytes`, `rsp_wen`, `rsp_wdata` and `rsp_ld_data` are all zero. The effective address is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_repl | input | 1 | Replicate (broadcast) load |
| req_ff | input | 1 | First-faulting request flag |
| req_imm_mode | input | 1 | 1 = immediate offset, 0 = register offset |
| req_dtype | input | 4 | Data-type code |
| req_base | input | 64 | Base address |
| req_imm | input | 8 | Signed immediate |
| req_off | input | 64 | Offset register value |
| req_base_sp | input | 1 | Base register is the stack pointer |
| req_align_en | input | 1 | Stack alignment check enabled |
| req_pred | input | 16 | Predicate, one bit per register byte |
| req_reg_data | input | 128 | Register data for stores |
| req_mem_data | input | 128 | Memory byte image for loads |
| rsp_valid | output | 1 | Result valid |
| rsp_ea | output | 64 | Effective address |
| rsp_bytes | output | 5 | Access size in bytes |
| rsp_wen | output | 16 | Store byte write enables |
| rsp_wdata | output | 128 | Store byte image |
| rsp_ld_data | output | 128 | Load register result |
| rsp_undef | output | 1 | Signed code used with a store |
| rsp_align_fault | output | 1 | Stack-pointer alignment fault |
| rsp_illegal | output | 1 | Illegal flag combination |

## Verification
The assertions assume that the request fields are stable and meaningful whenever `req_valid` is high. They also assume that the decoded memory element is never wider than its register lane. That assumption holds for every code, so every byte index stays inside the vector. The stimulus drives all inputs at the falling edge and takes random codes, flags, predicates and data over their whole ranges. It raises the replicate flag in only about one request in eight, so that the replicate path and its illegal mixes are reached without swamping ordinary traffic. Directed cases fill in every code for both directions, negative immediates, and each alignment-fault condition taken alone.

// File: rtl/vls_pkg.sv
`timescale 1ns/1ps
// Shared types for the contiguous vector load/store unit.
// Assumes: memory element log2 size never exceeds register lane log2 size.
package vls_pkg;

    typedef struct packed {
        logic [1:0] reg_l2;   // log2 of register lane bytes
        logic [1:0] mem_l2;   // log2 of memory element bytes
        logic       sext;     // 1 = sign extend on load
    } vls_fmt_t;

    // Map a data-type code to its lane/element widths and extension.
    function automatic vls_fmt_t vls_fmt_of(input logic [3:0] code);
        vls_fmt_t f;
        case (code)
            4'h0: f = '{2'd0, 2'd0, 1'b0};
            4'h1: f = '{2'd1, 2'd0, 1'b0};
            4'h2: f = '{2'd2, 2'd0, 1'b0};
            4'h3: f = '{2'd3, 2'd0, 1'b0};
            4'h4: f = '{2'd3, 2'd2, 1'b1};
            4'h5: f = '{2'd1, 2'd1, 1'b0};
            4'h6: f = '{2'd2, 2'd1, 1'b0};
            4'h7: f = '{2'd3, 2'd1, 1'b0};
            4'h8: f = '{2'd3, 2'd1, 1'b1};
            4'h9: f = '{2'd2, 2'd1, 1'b1};
            4'hA: f = '{2'd2, 2'd2, 1'b0};
            4'hB: f = '{2'd3, 2'd2, 1'b0};
            4'hC: f = '{2'd3, 2'd0, 1'b1};
            4'hD: f = '{2'd2, 2'd0, 1'b1};
            4'hE: f = '{2'd1, 2'd0, 1'b1};
            default: f = '{2'd3, 2'd3, 1'b0};
        endcase
        return f;
    endfunction

endpackage

// File: rtl/vls_dtype_dec.sv
`timescale 1ns/1ps
// Data-type decoder: turns the 4-bit code into lane/element widths and
// flags signed codes used with a store as undefined.
// Assumes: purely combinational, consumed by the request register stage.
module vls_dtype_dec
    import vls_pkg::*;
(
    input  logic [3:0] code,
    input  logic       is_store,
    output vls_fmt_t   fmt,
    output logic       undef
);

    // Decode the code and qualify the signed forms against stores.
    always_comb begin
        fmt   = vls_fmt_of(code);
        undef = is_store & fmt.sext;
    end

endmodule

// File: rtl/vls_agen.sv
`timescale 1ns/1ps
// Address generator: effective address and access size for the
// immediate, register-offset and replicate forms.
// Assumes: mem_l2 <= reg_l2, so the access never exceeds the vector.
module vls_agen #(
    parameter int ADDR_W  = 64,
    parameter int IMM_W   = 8,
    parameter int VL_LOG2 = 4
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [IMM_W-1:0]   imm,
    input  logic [ADDR_W-1:0]  off,
    input  logic               use_imm,
    input  logic               repl,
    input  logic [1:0]         reg_l2,
    input  logic [1:0]         mem_l2,
    output logic [ADDR_W-1:0]  ea,
    output logic [VL_LOG2:0]   acc_bytes
);

    localparam int SH_W = 8;

    logic [ADDR_W-1:0] imm_x;
    logic [ADDR_W-1:0] delta;
    logic [SH_W-1:0]   vec_sh;
    logic [SH_W-1:0]   sh;

    // Pick the scaled offset and the size exponent for the active form.
    always_comb begin
        imm_x  = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
        vec_sh = SH_W'(VL_LOG2) - SH_W'(reg_l2) + SH_W'(mem_l2);
        if (repl) begin
            sh    = SH_W'(mem_l2);
            delta = imm_x << sh;
        end else if (use_imm) begin
            sh    = vec_sh;
            delta = imm_x << sh;
        end else begin
            sh    = vec_sh;
            delta = off << mem_l2;
        end
        ea        = base + delta;
        acc_bytes = (VL_LOG2+1)'(1) << sh;
    end

endmodule

// File: rtl/vls_lane_xfer.sv
`timescale 1ns/1ps
// Lane data path: per-byte widening of memory elements into register
// lanes for loads, and per-byte packing with write enables for stores.
// Assumes: mem_l2 <= reg_l2; fault masking is done by the caller.
module vls_lane_xfer #(
    parameter int VL_BYTES = 16
) (
    input  logic [1:0]            reg_l2,
    input  logic [1:0]            mem_l2,
    input  logic                  sext,
    input  logic                  repl,
    input  logic [VL_BYTES-1:0]   pred,
    input  logic [VL_BYTES*8-1:0] mem_rdata,
    input  logic [VL_BYTES*8-1:0] reg_wdata,
    output logic [VL_BYTES*8-1:0] ld_lanes,
    output logic [VL_BYTES*8-1:0] st_bytes,
    output logic [VL_BYTES-1:0]   st_wen
);

    localparam int IDX_W  = $clog2(VL_BYTES);
    localparam int WIDE_W = IDX_W + 4;

    logic [7:0] mem_b [VL_BYTES];
    logic [7:0] reg_b [VL_BYTES];

    for (genvar b = 0; b < VL_BYTES; b++) begin : g_byte
        logic [WIDE_W-1:0] r_bytes, m_bytes;
        logic [WIDE_W-1:0] ld_lane, ld_k, ld_src, ld_idx, ld_sidx;
        logic [WIDE_W-1:0] st_lane, st_k, st_rpos, st_ridx;
        logic              ld_act, ld_sign, st_act;
        logic [7:0]        ld_byte, st_byte;

        assign mem_b[b] = mem_rdata[b*8 +: 8];
        assign reg_b[b] = reg_wdata[b*8 +: 8];

        // Load: pick source byte or extension fill for register byte b.
        always_comb begin
            r_bytes = WIDE_W'(1) << reg_l2;
            m_bytes = WIDE_W'(1) << mem_l2;
            ld_lane = WIDE_W'(b) >> reg_l2;
            ld_k    = WIDE_W'(b) & (r_bytes - WIDE_W'(1));
            ld_src  = repl ? '0 : ld_lane;
            ld_idx  = (ld_src << mem_l2) + ld_k;
            ld_sidx = (ld_src << mem_l2) + m_bytes - WIDE_W'(1);
            ld_act  = pred[IDX_W'(ld_lane << reg_l2)];
            ld_sign = sext & mem_b[ld_sidx[IDX_W-1:0]][7];
            if (!ld_act)
                ld_byte = '0;
            else if (ld_k < m_bytes)
                ld_byte = mem_b[ld_idx[IDX_W-1:0]];
            else
                ld_byte = {8{ld_sign}};
        end

        // Store: map memory byte b back to its lane and register byte.
        always_comb begin
            st_lane = WIDE_W'(b) >> mem_l2;
            st_k    = WIDE_W'(b) & (m_bytes - WIDE_W'(1));
            st_rpos = st_lane << reg_l2;
            st_ridx = st_rpos + st_k;
            st_act  = (st_rpos < WIDE_W'(VL_BYTES)) & pred[st_rpos[IDX_W-1:0]];
            st_byte = st_act ? reg_b[st_ridx[IDX_W-1:0]] : 8'h00;
        end

        assign ld_lanes[b*8 +: 8] = ld_byte;
        assign st_bytes[b*8 +: 8] = st_byte;
        assign st_wen[b]          = st_act;
    end

endmodule

// File: rtl/vls_contig_unit.sv
`timescale 1ns/1ps
// Predicated contiguous vector load/store unit (top). Decodes the data
// type, forms the effective address and size, builds the load lanes or
// the store image and enables, flags faults, and registers the result.
// Assumes: request fields are meaningful whenever req_valid is high.
module vls_contig_unit
    import vls_pkg::*;
#(
    parameter int VL_BYTES = 16,
    parameter int ADDR_W   = 64,
    parameter int IMM_W    = 8,
    localparam int VL_LOG2 = $clog2(VL_BYTES),
    localparam int VL_BITS = VL_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic                req_repl,
    input  logic                req_ff,
    input  logic                req_imm_mode,
    input  logic [3:0]          req_dtype,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [IMM_W-1:0]    req_imm,
    input  logic [ADDR_W-1:0]   req_off,
    input  logic                req_base_sp,
    input  logic                req_align_en,
    input  logic [VL_BYTES-1:0] req_pred,
    input  logic [VL_BITS-1:0]  req_reg_data,
    input  logic [VL_BITS-1:0]  req_mem_data,
    output logic                rsp_valid,
    output logic [ADDR_W-1:0]   rsp_ea,
    output logic [VL_LOG2:0]    rsp_bytes,
    output logic [VL_BYTES-1:0] rsp_wen,
    output logic [VL_BITS-1:0]  rsp_wdata,
    output logic [VL_BITS-1:0]  rsp_ld_data,
    output logic                rsp_undef,
    output logic                rsp_align_fault,
    output logic                rsp_illegal
);

    vls_fmt_t            fmt;
    logic                undef_c, align_c, illegal_c, fault_c;
    logic [ADDR_W-1:0]   ea_c;
    logic [VL_LOG2:0]    bytes_c;
    logic [VL_BITS-1:0]  ld_lanes_c, st_bytes_c;
    logic [VL_BYTES-1:0] st_wen_c;
    logic                st_q;

    vls_dtype_dec u_dec (
        .code     (req_dtype),
        .is_store (req_store),
        .fmt      (fmt),
        .undef    (undef_c)
    );

    vls_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .VL_LOG2(VL_LOG2)) u_agen (
        .base      (req_base),
        .imm       (req_imm),
        .off       (req_off),
        .use_imm   (req_imm_mode),
        .repl      (req_repl),
        .reg_l2    (fmt.reg_l2),
        .mem_l2    (fmt.mem_l2),
        .ea        (ea_c),
        .acc_bytes (bytes_c)
    );

    vls_lane_xfer #(.VL_BYTES(VL_BYTES)) u_lanes (
        .reg_l2    (fmt.reg_l2),
        .mem_l2    (fmt.mem_l2),
        .sext      (fmt.sext),
        .repl      (req_repl),
        .pred      (req_pred),
        .mem_rdata (req_mem_data),
        .reg_wdata (req_reg_data),
        .ld_lanes  (ld_lanes_c),
        .st_bytes  (st_bytes_c),
        .st_wen    (st_wen_c)
    );

    // Fault conditions: stack misalignment, bad flag mix, any fault.
    always_comb begin
        align_c   = req_base_sp & req_align_en & (req_base[3:0] != 4'h0);
        illegal_c = req_repl & (req_ff | req_store);
        fault_c   = undef_c | align_c | illegal_c;
    end

    // Result register: loads on a valid request, holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid       <= 1'b0;
            rsp_ea          <= '0;
            rsp_bytes       <= '0;
            rsp_wen         <= '0;
            rsp_wdata       <= '0;
            rsp_ld_data     <= '0;
            rsp_undef       <= 1'b0;
            rsp_align_fault <= 1'b0;
            rsp_illegal     <= 1'b0;
            st_q            <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_ea          <= ea_c;
                rsp_bytes       <= fault_c ? '0 : bytes_c;
                rsp_wen         <= (req_store && !fault_c) ? st_wen_c   : '0;
                rsp_wdata       <= (req_store && !fault_c) ? st_bytes_c : '0;
                rsp_ld_data     <= (!req_store && !fault_c) ? ld_lanes_c : '0;
                rsp_undef       <= undef_c;
                rsp_align_fault <= align_c;
                rsp_illegal     <= illegal_c;
                st_q            <= req_store;
            end
        end
    end

    // R1: response strobe follows the request strobe by one cycle.
    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R1: results hold while no request arrives.
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_ea) && $stable(rsp_ld_data) && $stable(rsp_wen)));
    // R3: an undefined store enables nothing.
    p_undef_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_undef) |-> (rsp_wen == '0));
    // R7: loads never enable a byte write.
    p_load_no_wen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !st_q) |-> (rsp_wen == '0));
    // R8: enabled bytes never exceed the access size.
    p_wen_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_wen) <= 32'(rsp_bytes)));
    // R10: misaligned stack base is flagged next cycle.
    p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_base_sp && req_align_en && (req_base[3:0] != 4'h0))
        |=> rsp_align_fault);
    // R11: replicate together with first-fault is flagged next cycle.
    p_illegal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_repl && req_ff) |=> rsp_illegal);
    // R12: a faulting request makes no access.
    p_fault_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_undef || rsp_align_fault || rsp_illegal))
        |-> (rsp_wen == '0 && rsp_ld_data == '0 && rsp_bytes == '0));

endmodule

// File: tb/vls_contig_unit_test.sv
`timescale 1ns/1ps
module vls_contig_unit_test;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, req_store, req_repl, req_ff, req_imm_mode;
    logic [3:0]   req_dtype;
    logic [63:0]  req_base, req_off;
    logic [7:0]   req_imm;
    logic         req_base_sp, req_align_en;
    logic [15:0]  req_pred;
    logic [127:0] req_reg_data, req_mem_data;
    logic         rsp_valid;
    logic [63:0]  rsp_ea;
    logic [4:0]   rsp_bytes;
    logic [15:0]  rsp_wen;
    logic [127:0] rsp_wdata, rsp_ld_data;
    logic         rsp_undef, rsp_align_fault, rsp_illegal;

    int n_checks = 0;
    int n_errs   = 0;

    logic [63:0]  e_ea;
    logic [4:0]   e_bytes;
    logic [15:0]  e_wen;
    logic [127:0] e_wdata, e_ld;
    logic         e_undef, e_align, e_illegal;

    always #2.5 clk = ~clk;

    vls_contig_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_repl(req_repl), .req_ff(req_ff), .req_imm_mode(req_imm_mode),
        .req_dtype(req_dtype), .req_base(req_base), .req_imm(req_imm),
        .req_off(req_off), .req_base_sp(req_base_sp), .req_align_en(req_align_en),
        .req_pred(req_pred), .req_reg_data(req_reg_data), .req_mem_data(req_mem_data),
        .rsp_valid(rsp_valid), .rsp_ea(rsp_ea), .rsp_bytes(rsp_bytes),
        .rsp_wen(rsp_wen), .rsp_wdata(rsp_wdata), .rsp_ld_data(rsp_ld_data),
        .rsp_undef(rsp_undef), .rsp_align_fault(rsp_align_fault),
        .rsp_illegal(rsp_illegal)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    endtask

    initial begin
        #1000000;
        n_checks++;
        n_errs++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Width table from the requirement on data-type codes (R2).
    task automatic dt_info(input logic [3:0] c, output int rb, output int mb, output bit sg);
        case (c)
            4'h0: begin rb = 1; mb = 1; sg = 0; end
            4'h1: begin rb = 2; mb = 1; sg = 0; end
            4'h2: begin rb = 4; mb = 1; sg = 0; end
            4'h3: begin rb = 8; mb = 1; sg = 0; end
            4'h4: begin rb = 8; mb = 4; sg = 1; end
            4'h5: begin rb = 2; mb = 2; sg = 0; end
            4'h6: begin rb = 4; mb = 2; sg = 0; end
            4'h7: begin rb = 8; mb = 2; sg = 0; end
            4'h8: begin rb = 8; mb = 2; sg = 1; end
            4'h9: begin rb = 4; mb = 2; sg = 1; end
            4'hA: begin rb = 4; mb = 4; sg = 0; end
            4'hB: begin rb = 8; mb = 4; sg = 0; end
            4'hC: begin rb = 8; mb = 1; sg = 1; end
            4'hD: begin rb = 4; mb = 1; sg = 1; end
            4'hE: begin rb = 2; mb = 1; sg = 1; end
            default: begin rb = 8; mb = 8; sg = 0; end
        endcase
    endtask

    // Reference model built lane by lane from R2..R12.
    task automatic model();
        int rb, mb, n, j;
        bit sg, fault;
        logic [63:0] ix, v;
        dt_info(req_dtype, rb, mb, sg);
        n  = 16 / rb;
        ix = {{56{req_imm[7]}}, req_imm};
        if (req_repl)          e_ea = req_base + ix * 64'(mb);
        else if (req_imm_mode) e_ea = req_base + ix * 64'(n * mb);
        else                   e_ea = req_base + req_off * 64'(mb);
        e_undef   = req_store && sg;
        e_align   = req_base_sp && req_align_en && (req_base[3:0] != 4'h0);
        e_illegal = req_repl && (req_ff || req_store);
        fault     = e_undef || e_align || e_illegal;
        e_bytes   = fault ? 5'd0 : (req_repl ? 5'(mb) : 5'(n * mb));
        e_wen = '0; e_wdata = '0; e_ld = '0;
        if (!fault) begin
            for (int i = 0; i < n; i++) begin
                if (req_pred[i*rb]) begin
                    if (req_store) begin
                        for (int k = 0; k < mb; k++) begin
                            e_wdata[(i*mb+k)*8 +: 8] = req_reg_data[(i*rb+k)*8 +: 8];
                            e_wen[i*mb+k] = 1'b1;
                        end
                    end else begin
                        j = req_repl ? 0 : i;
                        v = '0;
                        for (int k = 0; k < mb; k++)
                            v[k*8 +: 8] = req_mem_data[(j*mb+k)*8 +: 8];
                        if (sg && v[mb*8-1])
                            for (int k = mb; k < 8; k++) v[k*8 +: 8] = 8'hFF;
                        for (int k = 0; k < rb; k++)
                            e_ld[(i*rb+k)*8 +: 8] = v[k*8 +: 8];
                    end
                end
            end
        end
    endtask

    // Present the request at a falling edge, check after the next edge.
    task automatic issue();
        string ta, tl, tw;
        bit fault;
        @(negedge clk);
        req_valid = 1'b1;
        model();
        fault = e_undef || e_align || e_illegal;
        @(negedge clk);
        req_valid = 1'b0;
        ta = req_repl ? "R9 ea" : (req_imm_mode ? "R4 ea" : "R5 ea");
        tl = fault ? "R12 ld" : (req_repl ? "R9 ld" : "R2/R7 ld");
        tw = fault ? "R12 wen" : "R8 wen";
        chk("R1 valid", 128'(rsp_valid), 128'(1'b1));
        chk(ta, 128'(rsp_ea), 128'(e_ea));
        chk(fault ? "R12 bytes" : "R6 bytes", 128'(rsp_bytes), 128'(e_bytes));
        chk(tw, 128'(rsp_wen), 128'(e_wen));
        chk(fault ? "R12 wdata" : "R8 wdata", rsp_wdata, e_wdata);
        chk(tl, rsp_ld_data, e_ld);
        chk("R3 undef", 128'(rsp_undef), 128'(e_undef));
        chk("R10 align", 128'(rsp_align_fault), 128'(e_align));
        chk("R11 illegal", 128'(rsp_illegal), 128'(e_illegal));
    endtask

    task automatic defaults();
        req_store = 0; req_repl = 0; req_ff = 0; req_imm_mode = 1;
        req_dtype = 4'h0; req_base = 64'h1000; req_off = 64'd0; req_imm = 8'd0;
        req_base_sp = 0; req_align_en = 0; req_pred = 16'hFFFF;
        req_reg_data = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
        req_mem_data = 128'hf0e1d2c3b4a5968778695a4b3c2d1e0f;
    endtask

    initial begin
        logic [63:0]  hold_ea;
        logic [127:0] hold_ld;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        req_valid = 1'b0;
        defaults();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", 128'(rsp_valid), 128'(0));
        chk("R1 reset ea", 128'(rsp_ea), 128'(0));
        chk("R1 reset ld", rsp_ld_data, 128'(0));
        chk("R1 reset wen", 128'(rsp_wen), 128'(0));
        rst_n = 1'b1;

        // R2, R7: every load code, full predicate, sign-heavy data
        for (int c = 0; c < 16; c++) begin
            defaults(); req_dtype = 4'(c); issue();
        end
        // R3, R8: every store code, sparse predicate
        for (int c = 0; c < 16; c++) begin
            defaults(); req_store = 1; req_dtype = 4'(c); req_pred = 16'h5A3C; issue();
        end
        // R7: partial predicate on loads
        defaults(); req_dtype = 4'h4; req_pred = 16'h00F0; issue();
        defaults(); req_dtype = 4'hE; req_pred = 16'h0101; issue();
        // R4: negative immediate
        defaults(); req_dtype = 4'hB; req_imm = 8'hFE; issue();
        // R5: register offset with wrap
        defaults(); req_imm_mode = 0; req_dtype = 4'hF; req_off = 64'hFFFF_FFFF_FFFF_FFFF; issue();
        // R9: replicate with negative imm and register-offset mode set
        defaults(); req_repl = 1; req_imm_mode = 0; req_dtype = 4'hC; req_imm = 8'h81; req_pred = 16'h0F0F; issue();
        defaults(); req_repl = 1; req_dtype = 4'hA; issue();
        // R10: each condition alone and all together
        defaults(); req_base = 64'h1008; req_base_sp = 1; req_align_en = 1; issue();
        defaults(); req_base = 64'h1008; req_base_sp = 1; req_align_en = 0; issue();
        defaults(); req_base = 64'h1010; req_base_sp = 1; req_align_en = 1; issue();
        defaults(); req_base = 64'h1001; req_base_sp = 0; req_align_en = 1; issue();
        defaults(); req_store = 1; req_base = 64'h1003; req_base_sp = 1; req_align_en = 1; issue();
        // R11: replicate with first-fault, replicate with store
        defaults(); req_repl = 1; req_ff = 1; issue();
        defaults(); req_repl = 1; req_store = 1; req_dtype = 4'h3; issue();
        defaults(); req_ff = 1; req_dtype = 4'h7; issue();

        // R1: results hold while idle
        hold_ea = rsp_ea;
        hold_ld = rsp_ld_data;
        req_base = 64'hDEAD_0000; req_dtype = 4'h2; req_mem_data = '1;
        @(negedge clk);
        chk("R1 idle valid", 128'(rsp_valid), 128'(0));
        chk("R1 hold ea", 128'(rsp_ea), 128'(hold_ea));
        chk("R1 hold ld", rsp_ld_data, hold_ld);

        // Random traffic
        for (int t = 0; t < 400; t++) begin
            req_store    = $urandom_range(1, 0) == 1;
            req_repl     = $urandom_range(7, 0) == 0;
            req_ff       = $urandom_range(7, 0) == 0;
            req_imm_mode = $urandom_range(1, 0) == 1;
            req_dtype    = 4'($urandom_range(15, 0));
            req_base     = {$urandom, $urandom};
            req_off      = {$urandom, $urandom};
            req_imm      = 8'($urandom);
            req_base_sp  = $urandom_range(3, 0) == 0;
            req_align_en = $urandom_range(1, 0) == 1;
            req_pred     = 16'($urandom);
            req_reg_data = {$urandom, $urandom, $urandom, $urandom};
            req_mem_data = {$urandom, $urandom, $urandom, $urandom};
            issue();
        end

        summary();
        $finish;
    end

endmodule